// File: doc/BRIEF.md
# Trigger-Controlled Up-Counter

This block is an up-counter whose clocking and start are decided by a slave controller. A single trigger source, picked from three channel-derived inputs, can restart the count, gate it by level, start it once, or act as the count clock itself. The counter runs from zero up to a programmable reload limit and then wraps to zero. Each wrap, and each restart, produces a one-cycle update pulse.

Each rising edge of the selected trigger sets a sticky trigger flag. A sticky update flag records update pulses. Software clears either flag with a clear strobe. Four interrupt-enable bits mask the flags and two external channel requests onto one registered interrupt line. The enable that gates counting is held inside the block. A write strobe loads it, and event mode can also set it from a trigger edge.

Top module: `trig_slave_timer`

## Requirements
- R1: While `rst` is high, and after it falls, the count, update pulse, both flags, the count-enable and the interrupt line are all 0. The trigger selection resets to 000, which selects no source.
- R2: Mode 000 (free run) and the unused modes 001, 010 and 011 behave alike. The count rises by one on each clock edge where the count-enable held before that edge is 1, and it holds while that enable is 0.
- R3: Suppose the count equals `reload_i` on a clock edge where counting is allowed. At that edge the count becomes 0, `upd_o` is 1 for that cycle only, and the update flag is set.
- R4: Mode 100 (restart). A rising edge of the selected trigger makes the count 0 and pulses `upd_o`. This takes priority over a counting step in the same cycle.
- R5: Mode 101 (gate). The count advances only on edges where the count-enable is 1 and the selected trigger is high at that edge.
- R6: Mode 110 (one-shot start). A rising edge of the selected trigger sets the count-enable, so counting starts on the following edge. This set wins over a write of 0 in the same cycle.
- R7: Mode 111 (trigger as clock). With the count-enable at 1, the count advances once for each rising edge of the selected trigger and at no other time.
- R8: Trigger select 100 picks `ch0_edge_i`, 101 picks `ch0_filt_i` and 110 picks `ch1_filt_i`. Codes 111 and 000 to 011 give a constant low trigger.
- R9: A write of the trigger select takes effect only while the mode is 000. Writes made while the mode is non-zero are dropped.
- R10: A trigger rising edge is the selected trigger high while its copy registered on the previous edge is low. Each such edge sets the trigger flag, in every mode. The flag stays set until the clear strobe, and a set in the same cycle wins over the clear.
- R11: `irq_o` is registered one cycle after its sources. It is the OR of the following terms, each masked by its enable: the update flag with `irq_en_i[0]`, `cc_req_i[0]` with `irq_en_i[1]`, `cc_req_i[1]` with `irq_en_i[2]`, and the trigger flag with `irq_en_i[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Slave controller mode |
| tsel_wr_i | input | 1 | Write strobe for the trigger select |
| tsel_i | input | 3 | Trigger select value to write |
| cen_wr_i | input | 1 | Write strobe for the count-enable |
| cen_wdata_i | input | 1 | Count-enable value to write |
| reload_i | input | CNT_W | Reload limit (last value before wrap) |
| ch0_edge_i | input | 1 | Channel 0 both-edge detector output |
| ch0_filt_i | input | 1 | Filtered channel 0 |
| ch1_filt_i | input | 1 | Filtered channel 1 |
| cc_req_i | input | 2 | Channel 0/1 interrupt requests from capture logic |
| irq_en_i | input | 4 | Interrupt enables: update, ch0, ch1, trigger |
| flag_clr_i | input | 2 | Clear strobes: bit 0 update flag, bit 1 trigger flag |
| cnt_o | output | CNT_W | Current count |
| upd_o | output | 1 | One-cycle update pulse |
| upd_flag_o | output | 1 | Sticky update flag |
| trg_flag_o | output | 1 | Sticky trigger flag |
| cen_o | output | 1 | Count-enable state |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Each mode is driven with trigger pulses placed so that the mode's behaviour differs from a plain enabled counter. In gate mode, trigger levels are held for several cycles, which separates level gating from edge counting. In trigger-as-clock mode, single-cycle pulses show that each edge counts only once. Restart pulses that land on a wrap cycle show the restart priority. A long random phase mixes modes, selects, dropped select writes and flag clears, and catches any disagreement with the reference model in the cycle where it occurs.

// File: rtl/trig_slave_pkg.sv
package trig_slave_pkg;
  typedef enum logic [2:0] {
    SM_FREE  = 3'b000,
    SM_RES1  = 3'b001,
    SM_RES2  = 3'b010,
    SM_RES3  = 3'b011,
    SM_RESTART = 3'b100,
    SM_GATE  = 3'b101,
    SM_START = 3'b110,
    SM_EXTCK = 3'b111
  } smode_e;

  localparam logic [2:0] TS_CH0_EDGE = 3'b100;
  localparam logic [2:0] TS_CH0_FILT = 3'b101;
  localparam logic [2:0] TS_CH1_FILT = 3'b110;
endpackage

// File: rtl/trig_select.sv
module trig_select
  import trig_slave_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] tsel,
  input  logic       ch0_edge,
  input  logic       ch0_filt,
  input  logic       ch1_filt,
  output logic       lvl,
  output logic       rise
);
  logic lvl_q;

  always_comb begin
    case (tsel)
      TS_CH0_EDGE: lvl = ch0_edge;
      TS_CH0_FILT: lvl = ch0_filt;
      TS_CH1_FILT: lvl = ch1_filt;
      default:     lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R8: an unused select code never yields a trigger edge
  p_reserved_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (tsel == 3'b111) |-> !rise);
endmodule

// File: rtl/slave_ctrl.sv
module slave_ctrl
  import trig_slave_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  smode_e mode,
  input  logic   cen_wr,
  input  logic   cen_wdata,
  input  logic   trig_lvl,
  input  logic   trig_rise,
  output logic   tick,
  output logic   restart,
  output logic   cen
);
  always_ff @(posedge clk) begin
    if (rst) cen <= 1'b0;
    else begin
      if (cen_wr) cen <= cen_wdata;
      if (mode == SM_START && trig_rise) cen <= 1'b1;
    end
  end

  always_comb begin
    case (mode)
      SM_GATE:  tick = cen & trig_lvl;
      SM_EXTCK: tick = cen & trig_rise;
      default:  tick = cen;
    endcase
    restart = (mode == SM_RESTART) && trig_rise;
  end

  p_start_sets_cen_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == SM_START && trig_rise) |=> cen);
  p_gate_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == SM_GATE && !trig_lvl) |-> !tick);
endmodule

// File: rtl/cnt_core.sv
module cnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             upd
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      upd <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
      upd <= 1'b1;
    end else if (tick) begin
      if (cnt == reload) begin
        cnt <= '0;
        upd <= 1'b1;
      end else begin
        cnt <= cnt + ONE;
        upd <= 1'b0;
      end
    end else begin
      upd <= 1'b0;
    end
  end

  p_restart_zero_r4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0) && upd);
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && cnt == reload) |=> (cnt == '0) && upd);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt) && !upd);
endmodule

// File: rtl/trig_slave_timer.sv
module trig_slave_timer
  import trig_slave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_i,
  input  logic             tsel_wr_i,
  input  logic [2:0]       tsel_i,
  input  logic             cen_wr_i,
  input  logic             cen_wdata_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             ch0_edge_i,
  input  logic             ch0_filt_i,
  input  logic             ch1_filt_i,
  input  logic [1:0]       cc_req_i,
  input  logic [3:0]       irq_en_i,
  input  logic [1:0]       flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o,
  output logic             upd_flag_o,
  output logic             trg_flag_o,
  output logic             cen_o,
  output logic             irq_o
);
  smode_e     mode;
  logic [2:0] tsel_q;
  logic       trig_lvl, trig_rise, tick, restart;

  assign mode = smode_e'(mode_i);

  always_ff @(posedge clk) begin
    if (rst) tsel_q <= 3'b000;
    else if (tsel_wr_i && mode == SM_FREE) tsel_q <= tsel_i;
  end

  trig_select u_sel (
    .clk(clk), .rst(rst), .tsel(tsel_q),
    .ch0_edge(ch0_edge_i), .ch0_filt(ch0_filt_i), .ch1_filt(ch1_filt_i),
    .lvl(trig_lvl), .rise(trig_rise)
  );

  slave_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mode(mode),
    .cen_wr(cen_wr_i), .cen_wdata(cen_wdata_i),
    .trig_lvl(trig_lvl), .trig_rise(trig_rise),
    .tick(tick), .restart(restart), .cen(cen_o)
  );

  cnt_core #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart),
    .reload(reload_i), .cnt(cnt_o), .upd(upd_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_flag_o <= 1'b0;
      trg_flag_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      if (tick && reload_i == cnt_o || restart) upd_flag_o <= 1'b1;
      else if (flag_clr_i[0])                   upd_flag_o <= 1'b0;
      if (trig_rise)          trg_flag_o <= 1'b1;
      else if (flag_clr_i[1]) trg_flag_o <= 1'b0;
      irq_o <= (upd_flag_o & irq_en_i[0]) | (cc_req_i[0] & irq_en_i[1]) |
               (cc_req_i[1] & irq_en_i[2]) | (trg_flag_o & irq_en_i[3]);
    end
  end

  p_tsel_lock_r9: assert property (@(posedge clk) disable iff (rst)
    (mode != SM_FREE) |=> $stable(tsel_q));
  p_trg_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (trg_flag_o && !flag_clr_i[1]) |=> trg_flag_o);
  p_upd_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> upd_flag_o);
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_en_i == 4'b0000) |=> !irq_o);
endmodule

// File: tb/trig_slave_timer_bench.sv
`timescale 1ns/1ps
module trig_slave_timer_bench;
  localparam int W = 16;
  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] mode_i = '0, tsel_i = '0;
  logic tsel_wr_i = 0, cen_wr_i = 0, cen_wdata_i = 0;
  logic [W-1:0] reload_i = '0;
  logic ch0_edge_i = 0, ch0_filt_i = 0, ch1_filt_i = 0;
  logic [1:0] cc_req_i = '0, flag_clr_i = '0;
  logic [3:0] irq_en_i = '0;
  logic [W-1:0] cnt_o;
  logic upd_o, upd_flag_o, trg_flag_o, cen_o, irq_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trig_slave_timer #(.CNT_W(W)) u_trig_slave_timer (.*);

  // reference model
  int m_cnt = 0, m_tsel = 0;
  bit m_cen = 0, m_tq = 0, m_upd = 0, m_uf = 0, m_tf = 0, m_irq = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_tsel = 0; m_cen = 0; m_tq = 0;
      m_upd = 0; m_uf = 0; m_tf = 0; m_irq = 0;
    end else begin
      bit sel, rise, tick, rs, ncen;
      int md;
      md = int'(mode_i);
      sel = (m_tsel == 4) ? ch0_edge_i : (m_tsel == 5) ? ch0_filt_i :
            (m_tsel == 6) ? ch1_filt_i : 1'b0;
      rise = sel && !m_tq;
      ncen = m_cen;
      if (cen_wr_i) ncen = cen_wdata_i;
      if (md == 6 && rise) ncen = 1;
      tick = (md == 5) ? (m_cen && sel) : (md == 7) ? (m_cen && rise) : m_cen;
      rs = (md == 4) && rise;
      m_irq = (m_uf && irq_en_i[0]) || (cc_req_i[0] && irq_en_i[1]) ||
              (cc_req_i[1] && irq_en_i[2]) || (m_tf && irq_en_i[3]);
      m_upd = 0;
      if (rs) begin m_cnt = 0; m_upd = 1; end
      else if (tick) begin
        if (m_cnt == int'(reload_i)) begin m_cnt = 0; m_upd = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (m_upd) m_uf = 1; else if (flag_clr_i[0]) m_uf = 0;
      if (rise) m_tf = 1; else if (flag_clr_i[1]) m_tf = 0;
      if (tsel_wr_i && md == 0) m_tsel = int'(tsel_i);
      m_tq = sel;
      m_cen = ncen;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R2 R4 R5 R7 count", int'(cnt_o), m_cnt);
    chk("R3 update pulse", int'(upd_o), int'(m_upd));
    chk("R3 update flag", int'(upd_flag_o), int'(m_uf));
    chk("R10 trigger flag", int'(trg_flag_o), int'(m_tf));
    chk("R6 count enable", int'(cen_o), int'(m_cen));
    chk("R11 irq", int'(irq_o), int'(m_irq));
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr_tsel(logic [2:0] v);
    tsel_i = v; tsel_wr_i = 1; cyc(); tsel_wr_i = 0;
  endtask

  task automatic wr_cen(logic v);
    cen_wdata_i = v; cen_wr_i = 1; cyc(); cen_wr_i = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); cyc(3);
    chk("R1 reset count", int'(cnt_o), 0);
    chk("R1 reset cen", int'(cen_o), 0);
    rst = 0;
    cyc();
    chk("R1 after reset flags", int'({upd_o, upd_flag_o, trg_flag_o, irq_o}), 0);
    // R2 free run and wrap R3
    reload_i = 16'd5; irq_en_i = 4'b1111;
    wr_cen(1); cyc(3);
    chk("R2 counts three", int'(cnt_o), 3);
    cyc(8);
    mode_i = 3'b010; cyc(4);
    wr_cen(0); cyc(3);
    flag_clr_i = 2'b11; cyc(); flag_clr_i = 0;
    // R8 select ch0 filtered, R4 restart
    mode_i = 3'b000; wr_tsel(3'b101); wr_cen(1);
    reload_i = 16'd20; mode_i = 3'b100; cyc(4);
    ch0_filt_i = 1; cyc(); ch0_filt_i = 0; cyc(3);
    // R9 ignored select write, trigger flag stays clear
    flag_clr_i = 2'b10; cyc(); flag_clr_i = 0;
    wr_tsel(3'b110);
    ch1_filt_i = 1; cyc(2); ch1_filt_i = 0; cyc();
    chk("R9 dropped write, no flag", int'(trg_flag_o), 0);
    // R5 gate
    mode_i = 3'b101; cyc(2);
    ch0_filt_i = 1; cyc(4); ch0_filt_i = 0; cyc(3);
    // R6 one-shot start
    wr_cen(0); mode_i = 3'b110; cyc(2);
    ch0_filt_i = 1; cyc();
    chk("R6 start sets enable", int'(cen_o), 1);
    ch0_filt_i = 0; cyc(3);
    // R7 trigger as clock
    mode_i = 3'b111;
    for (int k = 0; k < 4; k++) begin ch0_filt_i = 1; cyc(); ch0_filt_i = 0; cyc(2); end
    // R8 edge-detect source and reserved code
    mode_i = 3'b000; wr_tsel(3'b100);
    ch0_edge_i = 1; cyc(); ch0_edge_i = 0; cyc();
    flag_clr_i = 2'b11; cyc(); flag_clr_i = 0;
    wr_tsel(3'b111);
    ch0_edge_i = 1; ch0_filt_i = 1; ch1_filt_i = 1; cyc(2);
    chk("R8 reserved select quiet", int'(trg_flag_o), 0);
    ch0_edge_i = 0; ch0_filt_i = 0; ch1_filt_i = 0; cyc();
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      mode_i = (r[3:0] < 4) ? r[6:4] : mode_i;
      tsel_wr_i = r[7]; tsel_i = {1'b1, r[9:8]};
      cen_wr_i = (r[12:10] == 0); cen_wdata_i = r[13];
      reload_i = 16'(r[16:14] + 1);
      ch0_edge_i = r[17]; ch0_filt_i = r[18] & r[19]; ch1_filt_i = r[20];
      cc_req_i = r[22:21]; irq_en_i = r[26:23];
      flag_clr_i = {r[27] & r[28], r[29] & r[30]};
      cyc();
    end
    tsel_wr_i = 0; cen_wr_i = 0; flag_clr_i = 0;
    cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule